// File: doc/BRIEF.md
# Bus master security gate

This block sits between a single bus master, for example a DMA engine, and the system interconnect. For every request it works out whether the target address is secure or non-secure, using a small range lookup of its own. It then compares that attribute with the security level that a pin assigns to the master. A non-secure master that aims at a secure address is refused. Every other request goes downstream unchanged, except that it carries a security attribute that shows where it is going.

The block has no register bank, and three input pins set all of its behaviour. One pin gives the master's security level. A second pin picks how a refused access ends: with an error response, or as a quiet access in which a read returns zero and a write is dropped. A third pin clears the failure interrupt. Any refusal sets this interrupt, and it stays set until the clear pin is driven. Both sides of the block use a valid/ready request channel and a valid/ready response channel. Responses come back to the master in the order its requests were accepted.

Top module: `mst_sec_gate`

## Requirements
- R1: When `cfg_nonsec_i` is 1 and the target address is secure, the request is refused, and `dn_req_valid_o` stays 0 for that request.
- R2: A request that is not refused appears on the downstream request channel in the same cycle, with the same address, write flag and write data. It is accepted upstream in the same cycle that the downstream side accepts it.
- R3: `dn_req_nonsec_o` is 1 when the target address is non-secure. It is 0 when a secure master (`cfg_nonsec_i` = 0) targets a secure address.
- R4: An address is secure if it lies inside one of the first `NUM_RGN` ranges, where each range includes both its base and its limit. Every address outside those ranges is non-secure.
- R5: The local response to a refused request appears in the cycle after the request is accepted. With `cfg_err_resp_i` = 1 at acceptance, this response has `up_rsp_err_o` = 1 and `up_rsp_rdata_o` = 0.
- R6: With `cfg_err_resp_i` = 0 at acceptance, a refused read completes with read data 0 and no error. A refused write completes with no error and never reaches the downstream channel.
- R7: `irq_o` is 0 after reset. It goes to 1 in the cycle after a refused request is accepted, and it stays at 1 until `irq_clr_i` is seen high.
- R8: In any cycle where `irq_clr_i` is high, `irq_o` is 0 in the next cycle, even if a refusal is accepted in the same cycle.
- R9: A downstream response is passed upstream in the same cycle with its read data and error flag unchanged, and `dn_rsp_ready_o` follows `up_rsp_ready_i`.
- R10: A refused request is accepted only when no forwarded response is outstanding. While a local response is waiting, no request of either kind is accepted.
- R11: While `MAX_OUT` forwarded responses are outstanding, a further forwarded request is neither accepted nor shown downstream.
- R12: After reset, `up_rsp_valid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_nonsec_i | input | 1 | Master security level: 1 for non-secure, 0 for secure |
| cfg_err_resp_i | input | 1 | Ending of a refused access: 1 gives an error response, 0 gives read-zero with the write dropped |
| irq_clr_i | input | 1 | Clears the failure interrupt |
| up_req_valid_i | input | 1 | Upstream request valid |
| up_req_ready_o | output | 1 | Upstream request accepted |
| up_req_addr_i | input | AW | Request address |
| up_req_write_i | input | 1 | 1 for a write, 0 for a read |
| up_req_wdata_i | input | DW | Write data |
| up_rsp_valid_o | output | 1 | Upstream response valid |
| up_rsp_ready_i | input | 1 | Master takes the response |
| up_rsp_rdata_o | output | DW | Response read data |
| up_rsp_err_o | output | 1 | Response error flag |
| dn_req_valid_o | output | 1 | Downstream request valid |
| dn_req_ready_i | input | 1 | Downstream accepts the request |
| dn_req_addr_o | output | AW | Forwarded address |
| dn_req_write_o | output | 1 | Forwarded write flag |
| dn_req_wdata_o | output | DW | Forwarded write data |
| dn_req_nonsec_o | output | 1 | Attribute of the forwarded access: 1 for non-secure |
| dn_rsp_valid_i | input | 1 | Downstream response valid |
| dn_rsp_ready_o | output | 1 | Gate takes the downstream response |
| dn_rsp_rdata_i | input | DW | Downstream read data |
| dn_rsp_err_i | input | 1 | Downstream error flag |
| irq_o | output | 1 | Sticky failure interrupt |

## Verification
Addresses are drawn in two ways: from the whole address space, and from the base and limit of each secure range and the addresses one below and one above them. The boundary addresses show whether the range compare includes both ends, and the random addresses show that everything outside the ranges counts as non-secure. Every address is tried with both master security levels and both settings of the reject response. This separates a forwarded access, where the attribute on the outgoing request is checked, from a refused read or write, where the error flag, the zero data and the absence of any downstream request are checked. Directed sequences cover the remaining cases. In one, a refused request is presented while forwarded responses are still outstanding. In another, forwarded requests are issued until the outstanding limit is reached. In a third, a refusal arrives while the clear pin is held high, which shows that the clear wins.

// File: rtl/msg_pkg.sv
package msg_pkg;
   localparam int unsigned RGN_MAX = 4;

   typedef enum logic {
      RT_FWD = 1'b0,
      RT_BLK = 1'b1
   } route_e;
endpackage

// File: rtl/sec_attr_lookup.sv
module sec_attr_lookup #(
   parameter int unsigned AW      = 32,
   parameter int unsigned NUM_RGN = 2,
   parameter logic [msg_pkg::RGN_MAX-1:0][AW-1:0] RGN_BASE  = '0,
   parameter logic [msg_pkg::RGN_MAX-1:0][AW-1:0] RGN_LIMIT = '0
) (
   input  logic [AW-1:0] addr_i,
   output logic          secure_o
);
   logic [NUM_RGN-1:0] hit;

   for (genvar g = 0; g < NUM_RGN; g++) begin : g_rgn
      assign hit[g] = (addr_i >= RGN_BASE[g]) && (addr_i <= RGN_LIMIT[g]);
   end

   assign secure_o = |hit;
endmodule

// File: rtl/reject_rsp.sv
module reject_rsp (
   input  logic clk,
   input  logic rst_n,
   input  logic take_i,
   input  logic err_sel_i,
   input  logic done_i,
   output logic pend_o,
   output logic err_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_o <= 1'b0;
         err_o  <= 1'b0;
      end else if (take_i) begin
         pend_o <= 1'b1;
         err_o  <= err_sel_i;
      end else if (pend_o && done_i) begin
         pend_o <= 1'b0;
      end
   end
endmodule

// File: rtl/fail_irq.sv
module fail_irq (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic irq_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     irq_o <= 1'b0;
      else if (clr_i) irq_o <= 1'b0;
      else if (set_i) irq_o <= 1'b1;
   end
endmodule

// File: rtl/mst_sec_gate.sv
module mst_sec_gate #(
   parameter int unsigned AW      = 32,
   parameter int unsigned DW      = 32,
   parameter int unsigned NUM_RGN = 2,
   parameter int unsigned MAX_OUT = 2,
   parameter logic [msg_pkg::RGN_MAX-1:0][AW-1:0] RGN_BASE =
      {32'h0000_0000, 32'h0000_0000, 32'h3000_0000, 32'h1000_0000},
   parameter logic [msg_pkg::RGN_MAX-1:0][AW-1:0] RGN_LIMIT =
      {32'h0000_0000, 32'h0000_0000, 32'h3000_FFFF, 32'h1FFF_FFFF}
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_nonsec_i,
   input  logic          cfg_err_resp_i,
   input  logic          irq_clr_i,
   input  logic          up_req_valid_i,
   output logic          up_req_ready_o,
   input  logic [AW-1:0] up_req_addr_i,
   input  logic          up_req_write_i,
   input  logic [DW-1:0] up_req_wdata_i,
   output logic          up_rsp_valid_o,
   input  logic          up_rsp_ready_i,
   output logic [DW-1:0] up_rsp_rdata_o,
   output logic          up_rsp_err_o,
   output logic          dn_req_valid_o,
   input  logic          dn_req_ready_i,
   output logic [AW-1:0] dn_req_addr_o,
   output logic          dn_req_write_o,
   output logic [DW-1:0] dn_req_wdata_o,
   output logic          dn_req_nonsec_o,
   input  logic          dn_rsp_valid_i,
   output logic          dn_rsp_ready_o,
   input  logic [DW-1:0] dn_rsp_rdata_i,
   input  logic          dn_rsp_err_i,
   output logic          irq_o
);
   import msg_pkg::*;

   localparam int unsigned CW = $clog2(MAX_OUT + 1);
   localparam logic [CW-1:0] MAX_C = CW'(MAX_OUT);

   if (NUM_RGN < 1 || NUM_RGN > RGN_MAX) begin : g_bad_rgn
      $error("mst_sec_gate: NUM_RGN must lie in 1..4");
   end
   if (MAX_OUT < 1) begin : g_bad_out
      $error("mst_sec_gate: MAX_OUT must be at least 1");
   end

   logic          tgt_secure;
   route_e        route;
   logic          lpend;
   logic          lerr;
   logic [CW-1:0] out_cnt;
   logic          room;
   logic          idle_dn;
   logic          rej_take;
   logic          fwd_take;
   logic          rsp_take;

   sec_attr_lookup #(
      .AW(AW), .NUM_RGN(NUM_RGN), .RGN_BASE(RGN_BASE), .RGN_LIMIT(RGN_LIMIT)
   ) u_lookup (
      .addr_i   (up_req_addr_i),
      .secure_o (tgt_secure)
   );

   assign route   = (cfg_nonsec_i && tgt_secure) ? RT_BLK : RT_FWD;
   assign room    = out_cnt < MAX_C;
   assign idle_dn = out_cnt == '0;

   // Request side
   assign dn_req_valid_o  = up_req_valid_i && (route == RT_FWD) && !lpend && room;
   assign dn_req_addr_o   = up_req_addr_i;
   assign dn_req_write_o  = up_req_write_i;
   assign dn_req_wdata_o  = up_req_wdata_i;
   assign dn_req_nonsec_o = cfg_nonsec_i || !tgt_secure;

   always_comb begin
      if (route == RT_BLK) up_req_ready_o = !lpend && idle_dn;
      else                 up_req_ready_o = !lpend && room && dn_req_ready_i;
   end

   assign rej_take = up_req_valid_i && (route == RT_BLK) && !lpend && idle_dn;
   assign fwd_take = dn_req_valid_o && dn_req_ready_i;
   assign rsp_take = dn_rsp_valid_i && dn_rsp_ready_o;

   // Outstanding forwarded responses
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) out_cnt <= '0;
      else if (fwd_take && !rsp_take) out_cnt <= out_cnt + CW'(1);
      else if (!fwd_take && rsp_take && !idle_dn) out_cnt <= out_cnt - CW'(1);
   end

   reject_rsp u_rej (
      .clk       (clk),
      .rst_n     (rst_n),
      .take_i    (rej_take),
      .err_sel_i (cfg_err_resp_i),
      .done_i    (up_rsp_ready_i),
      .pend_o    (lpend),
      .err_o     (lerr)
   );

   // Response side: the local response wins; a refusal is taken only when idle
   assign dn_rsp_ready_o = !lpend && up_rsp_ready_i;
   assign up_rsp_valid_o = lpend || dn_rsp_valid_i;
   assign up_rsp_rdata_o = lpend ? '0   : dn_rsp_rdata_i;
   assign up_rsp_err_o   = lpend ? lerr : dn_rsp_err_i;

   fail_irq u_irq (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (rej_take),
      .clr_i (irq_clr_i),
      .irq_o (irq_o)
   );
endmodule

// File: rtl/mst_sec_gate_chk.sv
module mst_sec_gate_chk #(
   parameter int unsigned DW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cfg_nonsec_i,
   input logic          irq_clr_i,
   input logic          up_req_valid_i,
   input logic          up_req_ready_o,
   input logic          up_rsp_valid_o,
   input logic [DW-1:0] up_rsp_rdata_o,
   input logic          dn_req_valid_o,
   input logic          dn_req_nonsec_o,
   input logic          irq_o
);
   logic local_take;
   assign local_take = up_req_valid_i && up_req_ready_o && !dn_req_valid_o;

   // R1: a non-secure master never reaches downstream with a secure attribute
   assert_no_ns_to_sec_R1: assert property (@(posedge clk) disable iff (!rst_n)
      dn_req_valid_o |-> !(cfg_nonsec_i && !dn_req_nonsec_o));

   assert_local_rsp_next_R5: assert property (@(posedge clk) disable iff (!rst_n)
      local_take |=> (up_rsp_valid_o && (up_rsp_rdata_o == '0)));

   assert_irq_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_o) |-> $past(local_take));

   assert_irq_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && !irq_clr_i) |=> irq_o);

   assert_clr_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
      irq_clr_i |=> !irq_o);

   assert_stall_on_local_R10: assert property (@(posedge clk) disable iff (!rst_n)
      local_take |=> !up_req_ready_o);
endmodule

bind mst_sec_gate mst_sec_gate_chk #(.DW(DW)) u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .cfg_nonsec_i    (cfg_nonsec_i),
   .irq_clr_i       (irq_clr_i),
   .up_req_valid_i  (up_req_valid_i),
   .up_req_ready_o  (up_req_ready_o),
   .up_rsp_valid_o  (up_rsp_valid_o),
   .up_rsp_rdata_o  (up_rsp_rdata_o),
   .dn_req_valid_o  (dn_req_valid_o),
   .dn_req_nonsec_o (dn_req_nonsec_o),
   .irq_o           (irq_o)
);

// File: tb/tb_mst_sec_gate.sv
module tb_mst_sec_gate;
   localparam int unsigned AW = 32;
   localparam int unsigned DW = 32;
   localparam logic [31:0] B0 = 32'h1000_0000, L0 = 32'h1FFF_FFFF;
   localparam logic [31:0] B1 = 32'h3000_0000, L1 = 32'h3000_FFFF;

   logic clk = 1'b0, rst_n = 1'b0;
   logic cfg_ns = 1'b0, cfg_er = 1'b0, clr = 1'b0;
   logic uq_v = 1'b0, uq_r, uq_w = 1'b0;
   logic [AW-1:0] uq_a = '0;
   logic [DW-1:0] uq_d = '0;
   logic us_v, us_r = 1'b1, us_e;
   logic [DW-1:0] us_d;
   logic dq_v, dq_r = 1'b1, dq_w, dq_ns;
   logic [AW-1:0] dq_a;
   logic [DW-1:0] dq_d;
   logic ds_v = 1'b0, ds_r, ds_e = 1'b0;
   logic [DW-1:0] ds_d = '0;
   logic irq;

   int total = 0, bad = 0;
   logic exp_irq = 1'b0;
   bit done = 0;

   always #10 clk = ~clk;

   mst_sec_gate #(
      .AW(AW), .DW(DW), .NUM_RGN(2), .MAX_OUT(2),
      .RGN_BASE ({32'h0, 32'h0, B1, B0}),
      .RGN_LIMIT({32'h0, 32'h0, L1, L0})
   ) dut (
      .clk(clk), .rst_n(rst_n),
      .cfg_nonsec_i(cfg_ns), .cfg_err_resp_i(cfg_er), .irq_clr_i(clr),
      .up_req_valid_i(uq_v), .up_req_ready_o(uq_r), .up_req_addr_i(uq_a),
      .up_req_write_i(uq_w), .up_req_wdata_i(uq_d),
      .up_rsp_valid_o(us_v), .up_rsp_ready_i(us_r), .up_rsp_rdata_o(us_d),
      .up_rsp_err_o(us_e),
      .dn_req_valid_o(dq_v), .dn_req_ready_i(dq_r), .dn_req_addr_o(dq_a),
      .dn_req_write_o(dq_w), .dn_req_wdata_o(dq_d), .dn_req_nonsec_o(dq_ns),
      .dn_rsp_valid_i(ds_v), .dn_rsp_ready_o(ds_r), .dn_rsp_rdata_i(ds_d),
      .dn_rsp_err_i(ds_e), .irq_o(irq)
   );

   function automatic bit in_sec(logic [31:0] a);
      return (a >= B0 && a <= L0) || (a >= B1 && a <= L1);
   endfunction

   task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic fwd_txn(logic [31:0] a, bit w, logic [31:0] wd, bit ns);
      logic [31:0] rd = $urandom;
      bit re = 1'($urandom % 2);
      @(negedge clk);
      cfg_ns = ns; uq_v = 1; uq_a = a; uq_w = w; uq_d = wd;
      #1;
      chk(dq_v == 1, "R2 dn valid", 64'(dq_v), 1);
      chk(dq_a == a && dq_w == w && dq_d == wd, "R2 fields", 64'(dq_a), 64'(a));
      chk(dq_ns == !in_sec(a), "R3/R4 attribute", 64'(dq_ns), 64'(!in_sec(a)));
      chk(uq_r == 1, "R2 ready", 64'(uq_r), 1);
      @(negedge clk);
      uq_v = 0; ds_v = 1; ds_d = rd; ds_e = re;
      #1;
      chk(us_v == 1 && us_d == rd && us_e == re, "R9 rsp pass", 64'(us_d), 64'(rd));
      chk(ds_r == 1, "R9 dn ready", 64'(ds_r), 1);
      @(negedge clk);
      ds_v = 0;
   endtask

   task automatic blk_txn(logic [31:0] a, bit w, bit er);
      @(negedge clk);
      cfg_ns = 1; cfg_er = er; uq_v = 1; uq_a = a; uq_w = w; uq_d = $urandom;
      #1;
      chk(dq_v == 0, "R1/R6 no downstream", 64'(dq_v), 0);
      chk(uq_r == 1, "R1 accepted", 64'(uq_r), 1);
      @(negedge clk);
      uq_v = 0;
      exp_irq = clr ? 1'b0 : 1'b1;
      #1;
      chk(us_v == 1, "R5 rsp valid", 64'(us_v), 1);
      chk(us_d == 0, "R5/R6 rdata zero", 64'(us_d), 0);
      chk(us_e == er, er ? "R5 error" : "R6 no error", 64'(us_e), 64'(er));
      chk(irq == exp_irq, "R7/R8 irq", 64'(irq), 64'(exp_irq));
   endtask

   task automatic any_txn(logic [31:0] a, bit w, bit ns, bit er);
      cfg_er = er;
      if (ns && in_sec(a)) blk_txn(a, w, er);
      else fwd_txn(a, w, $urandom, ns);
   endtask

   function automatic logic [31:0] pick_addr();
      logic [31:0] pts[8] = '{B0, B0 - 1, L0, L0 + 1, B1, B1 - 1, L1, L1 + 1};
      if ($urandom % 2) return $urandom;
      return pts[$urandom % 8];
   endfunction

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      rst_n = 1;
      #1;
      chk(irq == 0, "R7 reset irq", 64'(irq), 0);
      chk(us_v == 0, "R12 reset rsp", 64'(us_v), 0);

      // R4 boundaries
      any_txn(B0, 0, 1, 1);
      any_txn(L0, 1, 1, 0);
      any_txn(B0 - 1, 0, 1, 1);
      any_txn(L0 + 1, 1, 1, 1);
      any_txn(B1, 0, 0, 1);       // R3 secure master to secure target
      any_txn(L1 + 1, 0, 0, 0);   // R3 secure master to non-secure target

      // R8 clear held during a refusal
      @(negedge clk); clr = 1;
      blk_txn(B1 + 4, 0, 1);
      @(negedge clk); clr = 0; exp_irq = 0;

      // R10 refusal waits for an outstanding forwarded response
      @(negedge clk);
      cfg_ns = 0; uq_v = 1; uq_a = 32'h0000_0100; uq_w = 0;
      @(negedge clk);
      cfg_ns = 1; uq_a = B0; cfg_er = 1; ds_v = 1; ds_d = 32'h55;
      #1;
      chk(uq_r == 0 && dq_v == 0, "R10 refusal stalled", 64'(uq_r), 0);
      @(negedge clk);
      ds_v = 0;
      #1;
      chk(uq_r == 1, "R10 refusal taken when idle", 64'(uq_r), 1);
      @(negedge clk);
      uq_v = 0; exp_irq = 1;
      #1;
      chk(us_v == 1 && us_e == 1, "R10 local rsp", 64'(us_e), 1);
      chk(irq == 1, "R7 irq set", 64'(irq), 1);
      @(negedge clk);
      #1;
      chk(irq == 1, "R7 irq sticky", 64'(irq), 1);

      // R11 outstanding limit
      cfg_ns = 0; uq_v = 1; uq_a = 32'h4000_0000; uq_w = 1;
      @(negedge clk);
      @(negedge clk);
      #1;
      chk(uq_r == 0 && dq_v == 0, "R11 limit stall", 64'(dq_v), 0);
      uq_v = 0; ds_v = 1;
      @(negedge clk);
      @(negedge clk);
      ds_v = 0;
      @(negedge clk); clr = 1;
      @(negedge clk); clr = 0; exp_irq = 0;
      #1;
      chk(irq == 0, "R8 irq cleared", 64'(irq), 0);

      // random mix
      for (int i = 0; i < 300; i++) begin
         any_txn(pick_addr(), 1'($urandom % 2), 1'($urandom % 2), 1'($urandom % 2));
         if (i % 25 == 24) begin
            @(negedge clk); clr = 1;
            @(negedge clk); clr = 0; exp_irq = 0;
            #1;
            chk(irq == 0, "R8 periodic clear", 64'(irq), 0);
         end
      end
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule